// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns a single column command into the stream of column addresses that a synchronous DRAM burst visits. A command carries a start column, a three-bit burst-length code and an order select (incrementing or interleaved). From the clock after the command, the block presents one column per enabled clock. It marks the final beat of a finite burst and keeps running in full-page mode until it is told to stop.

Beats never leave the aligned block of burst-length columns that holds the start column. Only the low bits move, and the bits above the block boundary keep the value of the start column. A new command accepted during a burst drops whatever beats remain and starts over with the complete programmed length. A stop request ends the burst in progress. A stall input models clock suspend: while it is high the block ignores every input and holds its state. A reserved length code, or interleaved order with full page, raises an error flag, and the burst then runs as a single beat.

Top module: `burst_col_gen`

## Requirements
- R1: While and after reset, before any command, `valid_o`, `last_o` and `mode_err_o` are 0.
- R2: A command accepted at a clock edge (`start_i`=1, `stall_i`=0) makes `valid_o` 1 from the next edge, and `col_o` then equals the start column.
- R3: In incrementing order (`ilv_i`=0), beat k carries low bits (start+k) mod L, where L is the burst length. The column bits above the L-aligned block equal those of the start column on every beat. Example: L=8 and start 2 give 2,3,4,5,6,7,0,1.
- R4: In interleaved order (`ilv_i`=1), beat k carries low bits start XOR k. Example: L=8 and start 2 give 2,3,0,1,6,7,4,5.
- R5: `blen_i` codes are 000=1, 001=2, 010=4, 011=8 and 111=full page. A finite burst shows exactly L valid beats, `last_o` is 1 on the final beat only, and `valid_o` drops on the next clock.
- R6: In full page, the column increments through all 256 columns of the low 8 bits and wraps, bit 8 stays fixed, and `last_o` never goes to 1.
- R7: A stop request (`stop_i`=1, `start_i`=0, `stall_i`=0) during a burst makes `valid_o` 0 from the next clock.
- R8: A command accepted during a burst drops the old beats and runs the new burst for its full length. A command has priority over a stop request at the same clock.
- R9: While `stall_i`=1, `col_o`, `valid_o` and `last_o` hold, and `start_i` and `stop_i` are ignored.
- R10: Codes 100, 101 and 110, or code 111 with `ilv_i`=1, set `mode_err_o` to 1 for that burst, and the burst runs one beat with `last_o` set. `mode_err_o` follows the most recently accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Column command: begin a new burst |
| start_col_i | input | 9 | Start column of the command |
| blen_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 1 = interleaved order, 0 = incrementing |
| stop_i | input | 1 | End the current burst |
| stall_i | input | 1 | Clock suspend: hold all state |
| col_o | output | 9 | Column of the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Current beat is the last of a finite burst |
| mode_err_o | output | 1 | Last accepted command had an illegal mode |

## Verification
The assertions assume that `start_col_i` and the mode inputs are stable and known whenever `start_i` is sampled high, and that reset is held for at least one clock before use. The bench drives every input at the falling edge from a single driver task, so no input ever changes near a sampling edge. It issues commands only with defined values, and its reference model sees exactly the same values as the design. The stall, stop and interrupt sequences are placed mid-burst, where held or dropped beats are visible at the ports.

// File: rtl/burst_col_pkg.sv
// Shared encodings for the burst column address generator.
// Assumes a three-bit burst-length code as stated in the brief.
package burst_col_pkg;
    typedef enum logic [2:0] {
        BL_ONE   = 3'b000,
        BL_TWO   = 3'b001,
        BL_FOUR  = 3'b010,
        BL_EIGHT = 3'b011,
        BL_PAGE  = 3'b111
    } blen_code_e;
endpackage

// File: rtl/bcg_mode_decode.sv
// Decodes a burst-length code and order select into a wrap mask.
// The mask has ones on the column bits that move during the burst.
// Assumes PAGE_W >= 3. Illegal combinations give an error and length 1.
module bcg_mode_decode
    import burst_col_pkg::*;
#(
    parameter int PAGE_W = 8
) (
    input  logic [2:0]        code_i,
    input  logic              ilv_i,
    output logic [PAGE_W-1:0] mask_o,
    output logic              full_o,
    output logic              err_o
);
    localparam logic [PAGE_W-1:0] MASK_1 = '0;
    localparam logic [PAGE_W-1:0] MASK_2 = PAGE_W'(1);
    localparam logic [PAGE_W-1:0] MASK_4 = PAGE_W'(3);
    localparam logic [PAGE_W-1:0] MASK_8 = PAGE_W'(7);

    // Map the code to a mask, a full-page flag and an error flag.
    always_comb begin
        mask_o = MASK_1;
        full_o = 1'b0;
        err_o  = 1'b0;
        case (code_i)
            BL_ONE:   mask_o = MASK_1;
            BL_TWO:   mask_o = MASK_2;
            BL_FOUR:  mask_o = MASK_4;
            BL_EIGHT: mask_o = MASK_8;
            BL_PAGE: begin
                if (ilv_i) begin
                    err_o = 1'b1;
                end else begin
                    mask_o = '1;
                    full_o = 1'b1;
                end
            end
            default:  err_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/bcg_beat_counter.sv
// Tracks whether a burst is running and its beat index.
// Assumes mask_i and full_i are the latched mode of the current burst.
// A stall freezes everything. A start outranks a stop at the same clock.
module bcg_beat_counter #(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              stall_i,
    input  logic [PAGE_W-1:0] mask_i,
    input  logic              full_i,
    output logic              active_o,
    output logic [PAGE_W-1:0] beat_o,
    output logic              last_o
);
    localparam logic [PAGE_W-1:0] STEP = PAGE_W'(1);

    logic at_end;

    // A finite burst ends when the beat index reaches the block mask.
    assign at_end = !full_i && (beat_o == mask_i);
    assign last_o = active_o && at_end;

    // Advance, restart, stop or hold the beat state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            beat_o   <= '0;
        end else if (!stall_i) begin
            if (start_i) begin
                active_o <= 1'b1;
                beat_o   <= '0;
            end else if (active_o) begin
                if (stop_i || at_end) begin
                    active_o <= 1'b0;
                end else begin
                    beat_o <= beat_o + STEP;
                end
            end
        end
    end

    // R7
    stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i && !stall_i) |=> !active_o);
    // R5
    last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i && !stall_i) |=> !active_o);
    // R8
    restart_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !stall_i) |=> (active_o && beat_o == '0));
endmodule

// File: rtl/bcg_addr_mux.sv
// Forms the column of the current beat from the start column.
// Bits under the mask take the sequential or interleaved offset.
// All other bits keep the start column value.
module bcg_addr_mux #(
    parameter int COL_W  = 9,
    parameter int PAGE_W = 8
) (
    input  logic [COL_W-1:0]  base_i,
    input  logic [PAGE_W-1:0] beat_i,
    input  logic [PAGE_W-1:0] mask_i,
    input  logic              ilv_i,
    output logic [COL_W-1:0]  col_o
);
    logic [PAGE_W-1:0] base_lo;
    logic [PAGE_W-1:0] step_lo;
    logic [PAGE_W-1:0] merged_lo;

    assign base_lo = base_i[PAGE_W-1:0];

    // Choose the offset order for the moving bits.
    always_comb begin
        if (ilv_i) step_lo = base_lo ^ beat_i;
        else       step_lo = base_lo + beat_i;
    end

    assign merged_lo = (base_lo & ~mask_i) | (step_lo & mask_i);

    // Columns wider than a page carry fixed upper bits.
    generate
        if (COL_W > PAGE_W) begin : g_upper
            assign col_o = {base_i[COL_W-1:PAGE_W], merged_lo};
        end else begin : g_flat
            assign col_o = merged_lo;
        end
    endgenerate
endmodule

// File: rtl/burst_col_gen.sv
// Burst column address generator, top level.
// Latches the command, decodes its mode and steps through the beats.
// Assumes COL_W >= PAGE_W >= 3. The first beat appears one clock
// after the command is accepted.
module burst_col_gen #(
    parameter int COL_W  = 9,
    parameter int PAGE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       blen_i,
    input  logic             ilv_i,
    input  logic             stop_i,
    input  logic             stall_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             mode_err_o
);
    logic              accept;
    logic [PAGE_W-1:0] dec_mask;
    logic              dec_full;
    logic              dec_err;
    logic [COL_W-1:0]  base_q;
    logic [PAGE_W-1:0] mask_q;
    logic              full_q;
    logic              ilv_q;
    logic [PAGE_W-1:0] beat;

    assign accept = start_i && !stall_i;

    bcg_mode_decode #(.PAGE_W(PAGE_W)) u_dec (
        .code_i (blen_i),
        .ilv_i  (ilv_i),
        .mask_o (dec_mask),
        .full_o (dec_full),
        .err_o  (dec_err)
    );

    // Hold the command fields for the life of the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q     <= '0;
            mask_q     <= '0;
            full_q     <= 1'b0;
            ilv_q      <= 1'b0;
            mode_err_o <= 1'b0;
        end else if (accept) begin
            base_q     <= start_col_i;
            mask_q     <= dec_mask;
            full_q     <= dec_full;
            ilv_q      <= ilv_i;
            mode_err_o <= dec_err;
        end
    end

    bcg_beat_counter #(.PAGE_W(PAGE_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .stop_i   (stop_i),
        .stall_i  (stall_i),
        .mask_i   (mask_q),
        .full_i   (full_q),
        .active_o (valid_o),
        .beat_o   (beat),
        .last_o   (last_o)
    );

    bcg_addr_mux #(.COL_W(COL_W), .PAGE_W(PAGE_W)) u_mux (
        .base_i (base_q),
        .beat_i (beat),
        .mask_i (mask_q),
        .ilv_i  (ilv_q),
        .col_o  (col_o)
    );

    // R2
    first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (valid_o && col_o == $past(start_col_i)));
    // R3
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o) && !$past(accept))
        |-> ((col_o & ~COL_W'(mask_q)) == ($past(col_o) & ~COL_W'(mask_q))));
    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> ($stable(col_o) && $stable(valid_o) && $stable(last_o)));
    // R10
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && mode_err_o) |-> last_o);
endmodule

// File: tb/sim_burst_col_gen.sv
// Scoreboard bench: the driver runs a reference model and queues the
// expected outputs, and the monitor compares them after each rising edge.
module sim_burst_col_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [8:0] start_col_i = '0;
    logic [2:0] blen_i = '0;
    logic       ilv_i = 1'b0;
    logic       stop_i = 1'b0;
    logic       stall_i = 1'b0;
    logic [8:0] col_o;
    logic       valid_o, last_o, mode_err_o;

    always #5 clk = ~clk;

    burst_col_gen u0 (.*);

    typedef struct {
        logic       valid;
        logic [8:0] col;
        logic       last;
        logic       err;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    // reference model state
    logic       m_act = 0, m_full = 0, m_ilv = 0, m_err = 0;
    logic [7:0] m_k = 0, m_mask = 0;
    logic [8:0] m_base = 0;

    function automatic logic [8:0] m_col();
        logic [7:0] lo;
        lo = m_ilv ? (m_base[7:0] ^ m_k) : (m_base[7:0] + m_k);
        return {m_base[8], (m_base[7:0] & ~m_mask) | (lo & m_mask)};
    endfunction

    task automatic cyc(input logic st, input logic [8:0] sc, input logic [2:0] bl,
                       input logic il, input logic sp, input logic sl, input string tag);
        exp_t e;
        @(negedge clk);
        start_i = st; start_col_i = sc; blen_i = bl; ilv_i = il; stop_i = sp; stall_i = sl;
        if (!sl) begin
            if (st) begin
                m_act = 1; m_k = 0; m_base = sc; m_ilv = il; m_full = 0; m_err = 0;
                case (bl)
                    3'b000: m_mask = 8'h00;
                    3'b001: m_mask = 8'h01;
                    3'b010: m_mask = 8'h03;
                    3'b011: m_mask = 8'h07;
                    3'b111: if (il) begin m_err = 1; m_mask = 0; end
                            else begin m_full = 1; m_mask = 8'hFF; end
                    default: begin m_err = 1; m_mask = 0; end
                endcase
            end else if (m_act) begin
                if (sp || (!m_full && m_k == m_mask)) m_act = 0;
                else m_k = m_k + 8'd1;
            end
        end
        e.valid = m_act;
        e.col   = m_col();
        e.last  = m_act && !m_full && (m_k == m_mask);
        e.err   = m_err;
        e.tag   = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 9'h0, 3'b000, 0, 0, 0, tag);
    endtask

    task automatic go(input logic [8:0] sc, input logic [2:0] bl, input logic il,
                      input int n, input string tag);
        cyc(1, sc, bl, il, 0, 0, tag);
        idle(n, tag);
    endtask

    // Monitor: compare outputs against the queued expectation.
    always @(posedge clk) begin
        #3;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (valid_o !== e.valid || mode_err_o !== e.err ||
                (e.valid && (col_o !== e.col || last_o !== e.last))) begin
                errors++;
                $display("FAIL %s: got v=%0b col=%h last=%0b err=%0b exp v=%0b col=%h last=%0b err=%0b",
                         e.tag, valid_o, col_o, last_o, mode_err_o,
                         e.valid, e.col, e.last, e.err);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (valid_o !== 0 || last_o !== 0 || mode_err_o !== 0) begin
            errors++;
            $display("FAIL R1: got v=%0b last=%0b err=%0b exp 0 0 0", valid_o, last_o, mode_err_o);
        end
        rst_n = 1'b1;
        idle(2, "R1");
        go(9'h0A2, 3'b011, 0, 9, "R3");          // 2,3,4,5,6,7,0,1 with bit 8 fixed
        go(9'h1F2, 3'b011, 1, 9, "R4");          // 2,3,0,1,6,7,4,5
        go(9'h015, 3'b010, 1, 5, "R4");
        go(9'h13B, 3'b000, 0, 2, "R5");
        go(9'h13B, 3'b001, 0, 3, "R5");
        go(9'h13B, 3'b001, 1, 3, "R5");
        go(9'h0C6, 3'b010, 0, 5, "R5");
        go(9'h1FC, 3'b111, 0, 300, "R6");        // wraps 1FF -> 100
        cyc(0, 9'h0, 3'b000, 0, 1, 0, "R7");
        idle(3, "R7");
        go(9'h040, 3'b011, 0, 3, "R7");
        cyc(0, 9'h0, 3'b000, 0, 1, 0, "R7");
        idle(2, "R7");
        go(9'h08D, 3'b011, 0, 3, "R8");
        go(9'h1A1, 3'b010, 1, 6, "R8");
        go(9'h055, 3'b011, 0, 2, "R8");
        cyc(1, 9'h0E0, 3'b001, 0, 1, 0, "R8");  // start outranks stop
        idle(3, "R8");
        go(9'h035, 3'b011, 0, 2, "R9");
        cyc(0, 9'h0, 3'b000, 0, 0, 1, "R9");
        cyc(1, 9'h111, 3'b000, 0, 0, 1, "R9");
        cyc(0, 9'h0, 3'b000, 0, 1, 1, "R9");
        idle(7, "R9");
        go(9'h077, 3'b100, 0, 2, "R10");
        go(9'h078, 3'b101, 1, 2, "R10");
        go(9'h079, 3'b110, 0, 2, "R10");
        go(9'h07A, 3'b111, 1, 2, "R10");
        go(9'h07B, 3'b010, 0, 5, "R10");
        idle(2, "R10");
        repeat (2) @(posedge clk);
        #4;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got running exp finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule